// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic use an external byte-wide asynchronous static RAM of 1M locations of 8 bits each. The user side issues one request at a time: a read or a write, with a 20-bit address and, for a write, a data byte. A `busy` flag stays high while the access runs. A one-cycle `done` pulse marks the end of the access. For a read, `rdata` holds the captured byte from that pulse until the next read completes.

The memory side has an active-low select and an active-high select, active-low write and output strobes, the address, and a split data bus (value, driver enable, input). The chip counts as selected only while the low-active select is low and the high-active select is high. Each phase lasts a number of clock cycles. These counts are worked out at elaboration from nanosecond timing parameters and the clock period, rounding up. A parameter picks one of two write styles. In the default style the output strobe stays high during writes. In the other style it stays low, and the write pulse is stretched to cover the memory's output turn-off time.

Top module: `sram_seq`

## Requirements
- R1: While and after reset, until a request: `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `busy`=0, `done`=0.
- R2: A write accepted at a clock edge drives `mem_we_n` low from that edge for WP cycles, where WP is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK) and ceil(T_DS/CLK): 4 at the defaults (10 ns, 35/35/28 ns). While it is low, `mem_ce_n`=0 and `mem_ce2`=1. The address and the data value stay constant, and in the default style `mem_oe_n`=1.
- R3: In the cycle after `mem_we_n` rises, `mem_dq_oe` is still 1 and the address and data are unchanged. In the next cycle `done`=1 and `mem_dq_oe`=0.
- R4: A read holds the chip selected with `mem_we_n`=1 and `mem_oe_n`=0 for RD=ceil(T_RD/CLK) cycles (5 at 45 ns). It never drives the data bus while the memory is driving it. `done` rises in the same cycle `mem_oe_n` returns high, and `rdata` then holds the byte the memory presented.
- R5: `busy` is 1 from the cycle after acceptance up to the `done` cycle, where it is 0. A request raised while `busy`=1 is ignored: it changes no memory pin, and no access follows it.
- R6: A write that follows a read is delayed by one cycle. In that cycle the chip is deselected and `mem_dq_oe`=0, and then `mem_we_n` falls.
- R7: Whenever `busy`=0 the chip is in standby (`mem_ce_n`=1, `mem_ce2`=0) and `mem_dq_oe`=0.
- R8: With OE_LOW_WR=1, `mem_oe_n` stays 0 throughout the write pulse. The pulse lasts floor((T_HZ+T_DS)/CLK)+1 cycles if that is the largest candidate: 5 at 18+28 ns. `mem_dq_oe` stays 0 for the first ceil(T_HZ/CLK) cycles (2) and is 1 for the rest.
- R9: `done` is high for exactly one cycle per access, and `rdata` keeps its value across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last byte read |
| mem_ce_n | output | 1 | Low-active chip select |
| mem_ce2 | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data value driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
Two events can share one cycle: the `done` of one access and the acceptance of the next request. Equally, a new request can arrive in a cycle while an access is still running. The bench raises a request in the middle of a write pulse and checks that the address pins do not move and that no second access appears. It also issues a write straight after a read and judges the turnaround cycle by the pins. A bus-contention monitor flags any cycle in which the controller's driver and the memory model's output are on together.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WRITE,
    ST_HOLD,
    ST_READ
  } seq_state_t;

  function automatic int cyc_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int cyc_over(input int ns, input int clk_ns);
    return ns / clk_ns + 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int WP_CYC    = 4,
  parameter int RD_CYC    = 5,
  parameter int HZ_USE    = 0,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic capture,
  output logic busy,
  output logic done,
  output logic ce_n,
  output logic ce2,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_AT  = CNT_W'(WP_CYC - HZ_USE);
  localparam bit               DRV_NOW = (HZ_USE == 0);

  seq_state_t       state;
  logic             last_rd;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic             start_wr_now;

  assign accept       = (state == ST_IDLE) && req_valid;
  assign start_wr_now = (accept && req_write && !last_rd) || (state == ST_TURN);
  assign capture      = (state == ST_READ) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = WP_LOAD;
    if (accept && !req_write) begin
      tmr_load = 1'b1;
      tmr_val  = RD_LOAD;
    end else if (start_wr_now) begin
      tmr_load = 1'b1;
      tmr_val  = WP_LOAD;
    end
  end

  sram_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      last_rd <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ce_n    <= 1'b1;
      ce2     <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_wr_now) begin
        state   <= ST_WRITE;
        last_rd <= 1'b0;
        busy    <= 1'b1;
        ce_n    <= 1'b0;
        ce2     <= 1'b1;
        we_n    <= 1'b0;
        oe_n    <= !OE_LOW_WR;
        dq_oe   <= DRV_NOW;
      end else begin
        case (state)
          ST_IDLE: begin
            if (accept) begin
              busy <= 1'b1;
              if (req_write) begin
                state <= ST_TURN;
              end else begin
                state   <= ST_READ;
                last_rd <= 1'b1;
                ce_n    <= 1'b0;
                ce2     <= 1'b1;
                oe_n    <= 1'b0;
              end
            end
          end
          ST_WRITE: begin
            if (!dq_oe && tmr_cnt == DRV_AT) begin
              dq_oe <= 1'b1;
            end
            if (tmr_zero) begin
              state <= ST_HOLD;
              we_n  <= 1'b1;
              ce_n  <= 1'b1;
              ce2   <= 1'b0;
              oe_n  <= 1'b1;
            end
          end
          ST_HOLD: begin
            state <= ST_IDLE;
            dq_oe <= 1'b0;
            done  <= 1'b1;
            busy  <= 1'b0;
          end
          ST_READ: begin
            if (tmr_zero) begin
              state <= ST_IDLE;
              oe_n  <= 1'b1;
              ce_n  <= 1'b1;
              ce2   <= 1'b0;
              done  <= 1'b1;
              busy  <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: write strobe only while the chip is selected
  a_r2_we_selected: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && ce2));

  // R4: no driver while the memory outputs are on
  a_r4_read_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ce2 && we_n && !oe_n) |-> !dq_oe);

  // R3: driver still on in the cycle the write ends
  a_r3_hold_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);

  // R5: busy drops with done
  a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: standby whenever idle
  a_r7_standby_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ce_n && !ce2 && !dq_oe));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: turnaround cycle keeps the bus quiet
  a_r6_turn_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |-> (ce_n && !dq_oe && we_n));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WP_NS   = 35,
  parameter int T_AW_NS   = 35,
  parameter int T_DS_NS   = 28,
  parameter int T_HZ_NS   = 18,
  parameter int T_RD_NS   = 45,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int DS_CYC  = cyc_up(T_DS_NS, CLK_NS);
  localparam int HZ_USE  = OE_LOW_WR ? cyc_up(T_HZ_NS, CLK_NS) : 0;
  localparam int WP_BASE = max2(max2(cyc_up(T_WP_NS, CLK_NS), cyc_up(T_AW_NS, CLK_NS)), DS_CYC);
  localparam int WP_TURN = OE_LOW_WR ? max2(cyc_over(T_HZ_NS + T_DS_NS, CLK_NS), HZ_USE + DS_CYC) : 0;
  localparam int WP_CYC  = max2(max2(WP_BASE, WP_TURN), 1);
  localparam int RD_CYC  = max2(cyc_up(T_RD_NS, CLK_NS), 1);
  localparam int CNT_W   = $clog2(max2(WP_CYC, RD_CYC) + 1);

  logic accept;
  logic capture;

  sram_seq_ctrl #(
    .CNT_W     (CNT_W),
    .WP_CYC    (WP_CYC),
    .RD_CYC    (RD_CYC),
    .HZ_USE    (HZ_USE),
    .OE_LOW_WR (OE_LOW_WR)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .capture   (capture),
    .busy      (busy),
    .done      (done),
    .ce_n      (mem_ce_n),
    .ce2       (mem_ce2),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rdata     (rdata)
  );

  // R2: address and data hold still through the write pulse
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

endmodule

// File: tb/test_sram_seq.sv
module test_sram_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rdata;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [19:0] mem_addr;
  logic [7:0]  mem_dq_o, mem_dq_i;

  logic        v_valid = 1'b0;
  logic        v_busy, v_done, v_ce_n, v_ce2, v_we_n, v_oe_n, v_dq_oe;
  logic [7:0]  v_rdata, v_dq_o;
  logic [19:0] v_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int conflicts = 0;

  always #5 clk = ~clk;

  sram_seq i_sram_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  sram_seq #(.OE_LOW_WR(1'b1)) i_sram_seq_oel (
    .clk(clk), .rst(rst), .req_valid(v_valid), .req_write(1'b1),
    .req_addr(20'h00042), .req_wdata(8'h5A), .busy(v_busy), .done(v_done),
    .rdata(v_rdata), .mem_ce_n(v_ce_n), .mem_ce2(v_ce2), .mem_we_n(v_we_n),
    .mem_oe_n(v_oe_n), .mem_addr(v_addr), .mem_dq_o(v_dq_o),
    .mem_dq_oe(v_dq_oe), .mem_dq_i(8'h00)
  );

  // memory model: 256 bytes on the low address bits
  logic [7:0]  mem [0:255];
  logic        sel, mem_drv, prev_we_low;
  logic [7:0]  pend_a, pend_d;
  assign sel      = !mem_ce_n && mem_ce2;
  assign mem_drv  = sel && mem_we_n && !mem_oe_n;
  assign mem_dq_i = mem_drv ? mem[mem_addr[7:0]] : 8'h00;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hC3);
    prev_we_low = 1'b0;
  end

  always @(negedge clk) begin
    if (mem_dq_oe && mem_drv) conflicts++;
    if (sel && !mem_we_n && mem_dq_oe) begin
      pend_a = mem_addr[7:0];
      pend_d = mem_dq_o;
    end
    if (prev_we_low && mem_we_n) mem[pend_a] = pend_d;
    prev_we_low = !mem_we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    check(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n, "R1 pins", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
    check(!mem_dq_oe && !busy && !done, "R1 status", {mem_dq_oe, busy, done}, 0);
  endtask

  task automatic t_write(input logic [19:0] a, input logic [7:0] d, input bit turn);
    int cnt = 0;
    bit ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R5 busy after accept", busy, 1);
    if (turn) begin
      check(mem_we_n && mem_ce_n && !mem_dq_oe, "R6 turnaround", {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b110);
      @(negedge clk);
    end
    while (!mem_we_n && cnt < 50) begin
      if (mem_addr != a || mem_dq_o != d || !mem_oe_n || mem_ce_n || !mem_ce2) ok = 1'b0;
      cnt++;
      @(negedge clk);
    end
    check(cnt == 4, "R2 pulse length", cnt, 4);
    check(ok, "R2 pins stable in pulse", ok, 1);
    check(mem_dq_oe && mem_addr == a && mem_dq_o == d, "R3 hold cycle", mem_dq_oe, 1);
    @(negedge clk);
    check(done && !busy && !mem_dq_oe, "R3 done after hold", {done, busy, mem_dq_oe}, 3'b100);
    @(negedge clk);
    check(!done, "R9 done single", done, 0);
    check(mem_ce_n && !mem_ce2 && !mem_dq_oe, "R7 standby", {mem_ce_n, mem_ce2, mem_dq_oe}, 3'b100);
  endtask

  task automatic t_read(input logic [19:0] a, input logic [7:0] exp);
    int cnt = 0;
    bit ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!mem_oe_n && cnt < 50) begin
      if (mem_dq_oe || !mem_we_n || mem_ce_n || !mem_ce2 || done || !busy) ok = 1'b0;
      cnt++;
      @(negedge clk);
    end
    check(cnt == 5, "R4 read length", cnt, 5);
    check(ok, "R4 read pins", ok, 1);
    check(done && !busy, "R4 done with oe rise", {done, busy}, 2'b10);
    check(rdata == exp, "R4 read data", rdata, exp);
  endtask

  task automatic t_ignore();
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00011; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00099;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr == 20'h00011, "R5 ignored request", mem_addr, 20'h11);
    while (!done && guard < 50) begin guard++; @(negedge clk); end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(mem_ce_n && !busy, "R5 no extra access", {mem_ce_n, busy}, 2'b10);
    end
  endtask

  task automatic t_variant();
    int cnt = 0;
    bit ok_oe = 1'b1, ok_drv = 1'b1;
    @(negedge clk);
    v_valid = 1'b1;
    @(negedge clk);
    v_valid = 1'b0;
    while (!v_we_n && cnt < 50) begin
      if (v_oe_n) ok_oe = 1'b0;
      if (v_dq_oe != (cnt >= 2)) ok_drv = 1'b0;
      cnt++;
      @(negedge clk);
    end
    check(cnt == 5, "R8 stretched pulse", cnt, 5);
    check(ok_oe, "R8 oe low in write", ok_oe, 1);
    check(ok_drv, "R8 delayed driver", ok_drv, 1);
    @(negedge clk);
    check(v_done, "R8 done", v_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(20'hABC12, 8'h3C, 1'b0);
    t_read(20'hABC12, 8'h3C);
    t_write(20'hFFFFF, 8'hFF, 1'b1);
    t_read(20'h00034, 8'h34 ^ 8'hC3);
    t_read(20'hFFFFF, 8'hFF);
    t_write(20'h00000, 8'h00, 1'b1);
    t_read(20'h00000, 8'h00);
    t_write(20'h00005, 8'hA5, 1'b1);
    check(rdata == 8'h00, "R9 rdata held over write", rdata, 0);
    t_ignore();
    t_read(20'h00099, 8'h99 ^ 8'hC3);
    t_read(20'h00011, 8'h77);
    t_variant();
    check(conflicts == 0, "R4 bus contention", conflicts, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule